// File: doc/BRIEF.md
# LPC Host I/O Cycle Engine

This block turns a handful of register writes into a burst of byte-wide I/O cycles on a low pin count bus. Software loads a cycle count, a command word and a 16-bit port address. For a write it also stages the payload bytes in a transmit byte queue. A single start write then runs the whole burst. Each bus cycle moves exactly one byte. The port either advances by one per cycle or stays on the base port, which suits stream-style peripherals. For a read, the returned bytes collect in a receive byte queue, and software drains them once the burst has finished.

The bus side runs on the same clock as the register side. It drives the framing strobe and the 4-bit multiplexed address/data lines. It honours target wait codes in the SYNC phase and gives up on an error code or on a target that keeps waiting too long. Software learns the outcome by polling the status register, or through a level interrupt that is raised when a burst ends.

Top module: `lpc_io_host`

## Requirements
- R1: After reset, status (offset 0x04) reads 0x1 (idle set, success clear), the interrupt register (0x08) reads 0, `irq` is low, `lframe_n` is high and `lad_oe` is low.
- R2: Writing a 1 in bit 0 of offset 0x00 while idle, with a valid count, starts the burst. While the burst runs, status bit 0 reads 0. When the burst ends, status reads 0x3 (bit 0 idle, bit 1 last burst succeeded).
- R3: A write cycle lasts 13 clocks with no waits. It sends 0000 with `lframe_n` low for one clock, then the direction nibble 0010, then the four port nibbles most significant first, then the data byte low nibble first. It then turns the bus around for 2 clocks, samples SYNC, and turns around for 2 more clocks. Successive cycles of one burst start 14 clocks apart.
- R4: A read cycle sends the direction nibble 0000 and the port nibbles, turns around for 2 clocks, samples SYNC, takes the data byte low nibble first, and turns around for 2 clocks. The bytes are returned in cycle order by reads of offset 0x28, and each read pops one byte. A read of an empty receive queue returns 0.
- R5: Command bit 0 selects a write (1) or a read (0). With command bit 3 clear, cycle n of the burst uses port base+n. With bit 3 set, every cycle uses the base port (offset 0x20, bits 15:0).
- R6: Bytes written to offset 0x24 (bits 7:0) are sent in the order they were pushed. The queue holds up to 16 bytes. An empty queue supplies 0x00.
- R7: SYNC codes 0101 and 0110 make the engine keep waiting. A cycle that sees up to 256 wait codes followed by 0000 completes normally.
- R8: Any other SYNC code than 0000, 0101 or 0110 (for example 1010) ends the burst with an error. Status bit 1 clears, the remaining cycles are dropped, and the engine returns to idle.
- R9: A 257th consecutive wait code in one cycle ends the burst with an error, in the same way as R8.
- R10: A start with a count of 0 or above 16 finishes at once with an error. No bus cycle is run, and done is set.
- R11: Interrupt register bit 1 is set at the end of every burst, including one that ends in error, and is cleared by writing a 1 to it. Bit 0 is a read/write enable. `irq` equals enable AND bit 1.
- R12: While a burst is active, writes to the count, command, port and transmit registers are ignored, and so is a further start.
- R13: A burst of 16 cycles, the maximum, runs to completion with every byte in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common register and bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at 0x28) |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Level interrupt: completion AND enable |
| lframe_n | output | 1 | Active-low cycle framing strobe |
| lad_out | output | 4 | Nibble driven onto the bus |
| lad_oe | output | 1 | Drive enable for `lad_out` |
| lad_in | input | 4 | Nibble sampled from the bus |

## Verification
A target model counts clocks from each framing strobe. It logs the direction, port and write nibbles, and answers SYNC with a programmable number of wait codes, an error code, or returned data. Bursts that write to incrementing ports and bursts that read from a fixed port show whether the address step and the byte order follow command bit 3. Runs with exactly 256 and with 257 wait codes locate the timeout boundary, and an error code partway through a three-cycle read shows that the remaining cycles are abandoned. Register writes made while a burst is running, followed by read-back of the count, command and port registers and by a later single-byte write, show that the busy window really is closed to software.

// File: rtl/lpcio_pkg.sv
package lpcio_pkg;

  localparam logic [7:0] OFS_GO   = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h04;
  localparam logic [7:0] OFS_INT  = 8'h08;
  localparam logic [7:0] OFS_LEN  = 8'h10;
  localparam logic [7:0] OFS_CTL  = 8'h14;
  localparam logic [7:0] OFS_PORT = 8'h20;
  localparam logic [7:0] OFS_TXB  = 8'h24;
  localparam logic [7:0] OFS_RXB  = 8'h28;

  localparam logic [3:0] NIB_FRAME  = 4'b0000;
  localparam logic [3:0] NIB_IO_RD  = 4'b0000;
  localparam logic [3:0] NIB_IO_WR  = 4'b0010;
  localparam logic [3:0] SYNC_READY = 4'b0000;
  localparam logic [3:0] SYNC_SHORT = 4'b0101;
  localparam logic [3:0] SYNC_LONG  = 4'b0110;

  typedef enum logic [3:0] {
    PH_IDLE, PH_START, PH_CTDIR, PH_ADDR, PH_WDATA,
    PH_TAR_A, PH_SYNC, PH_RDATA, PH_TAR_B
  } phase_t;

  // port used by cycle idx of a burst
  function automatic logic [15:0] cycle_port(input logic [15:0] base,
                                             input logic [7:0] idx,
                                             input logic fixed);
    return fixed ? base : base + {8'd0, idx};
  endfunction

  // nibble sel of a port, 0 = most significant
  function automatic logic [3:0] port_nibble(input logic [15:0] port,
                                             input logic [1:0] sel);
    logic [15:0] sh;
    sh = port >> {(2'd3 - sel), 2'b00};
    return sh[3:0];
  endfunction

  function automatic logic burst_len_ok(input logic [7:0] len,
                                        input int unsigned maxb);
    return (len != 8'd0) && (32'(len) <= maxb);
  endfunction

endpackage

// File: rtl/lpcio_fifo.sv
module lpcio_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;

  wire do_push = push && !full;
  wire do_pop  = pop && !empty;

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign head  = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      if (do_push && !do_pop)      cnt <= cnt + 1'b1;
      else if (do_pop && !do_push) cnt <= cnt - 1'b1;
    end
  end

  // R6
  fifo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> full)
    else $error("full queue lost its contents");

  // R6
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty)
    else $error("pop of empty queue changed occupancy");

endmodule

// File: rtl/lpcio_cycle.sv
module lpcio_cycle
  import lpcio_pkg::*;
#(
  parameter int WAIT_MAX = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic        wr,
  input  logic [15:0] port,
  input  logic [7:0]  wbyte,
  input  logic [3:0]  lad_in,
  output logic        lframe_n,
  output logic [3:0]  lad_out,
  output logic        lad_oe,
  output logic        cyc_done,
  output logic        cyc_fail,
  output logic [7:0]  rbyte
);
  localparam int WCW = $clog2(WAIT_MAX + 1);

  phase_t         ph;
  logic [1:0]     nib;
  logic           wr_q;
  logic [15:0]    port_q;
  logic [7:0]     wb_q, rb_q;
  logic [WCW-1:0] wcnt;

  // named events of the SYNC phase
  wire in_sync    = (ph == PH_SYNC);
  wire sync_ready = in_sync && (lad_in == SYNC_READY);
  wire sync_wait  = in_sync && ((lad_in == SYNC_SHORT) || (lad_in == SYNC_LONG));
  wire sync_bad   = in_sync && !sync_ready && !sync_wait;
  wire wait_over  = sync_wait && (wcnt == WCW'(WAIT_MAX));

  assign cyc_fail = sync_bad || wait_over;
  assign cyc_done = (ph == PH_TAR_B) && (nib == 2'd1);
  assign rbyte    = rb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      nib    <= '0;
      wr_q   <= 1'b0;
      port_q <= '0;
      wb_q   <= '0;
      rb_q   <= '0;
      wcnt   <= '0;
    end else begin
      case (ph)
        PH_IDLE: if (go) begin
          ph     <= PH_START;
          wr_q   <= wr;
          port_q <= port;
          wb_q   <= wbyte;
          wcnt   <= '0;
          nib    <= '0;
        end
        PH_START: ph <= PH_CTDIR;
        PH_CTDIR: begin
          ph  <= PH_ADDR;
          nib <= '0;
        end
        PH_ADDR: begin
          if (nib == 2'd3) begin
            nib <= '0;
            ph  <= wr_q ? PH_WDATA : PH_TAR_A;
          end else nib <= nib + 2'd1;
        end
        PH_WDATA: begin
          if (nib == 2'd1) begin
            nib <= '0;
            ph  <= PH_TAR_A;
          end else nib <= nib + 2'd1;
        end
        PH_TAR_A: begin
          if (nib == 2'd1) begin
            nib <= '0;
            ph  <= PH_SYNC;
          end else nib <= nib + 2'd1;
        end
        PH_SYNC: begin
          if (cyc_fail) ph <= PH_IDLE;
          else if (sync_ready) begin
            nib <= '0;
            ph  <= wr_q ? PH_TAR_B : PH_RDATA;
          end else wcnt <= wcnt + 1'b1;
        end
        PH_RDATA: begin
          if (nib[0]) rb_q[7:4] <= lad_in;
          else        rb_q[3:0] <= lad_in;
          if (nib == 2'd1) begin
            nib <= '0;
            ph  <= PH_TAR_B;
          end else nib <= nib + 2'd1;
        end
        PH_TAR_B: begin
          if (nib == 2'd1) ph <= PH_IDLE;
          else nib <= nib + 2'd1;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    lframe_n = (ph != PH_START);
    lad_oe   = 1'b0;
    lad_out  = 4'hF;
    case (ph)
      PH_START: begin
        lad_oe  = 1'b1;
        lad_out = NIB_FRAME;
      end
      PH_CTDIR: begin
        lad_oe  = 1'b1;
        lad_out = wr_q ? NIB_IO_WR : NIB_IO_RD;
      end
      PH_ADDR: begin
        lad_oe  = 1'b1;
        lad_out = port_nibble(port_q, nib);
      end
      PH_WDATA: begin
        lad_oe  = 1'b1;
        lad_out = nib[0] ? wb_q[7:4] : wb_q[3:0];
      end
      PH_TAR_A: lad_oe = (nib == 2'd0);
      default: ;
    endcase
  end

  // R3
  lframe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lframe_n) |=> lframe_n)
    else $error("framing strobe longer than one clock");

  // R3
  frame_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lframe_n |=> (lad_oe && lframe_n))
    else $error("direction nibble not driven after frame");

  // R9
  wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_sync |-> (wcnt <= WCW'(WAIT_MAX)))
    else $error("wait counter beyond limit");

  // R8
  fail_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_fail |=> (lframe_n && !lad_oe))
    else $error("bus not released after failed cycle");

endmodule

// File: rtl/lpc_io_host.sv
module lpc_io_host
  import lpcio_pkg::*;
#(
  parameter int BURST_MAX = 16,
  parameter int WAIT_MAX  = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  input  logic        reg_rd,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        lframe_n,
  output logic [3:0]  lad_out,
  output logic        lad_oe,
  input  logic [3:0]  lad_in
);
  localparam int IW = $clog2(BURST_MAX + 1);

  logic [7:0]    len_q;
  logic          dir_q, fixed_q;
  logic [31:0]   port_q;
  logic          busy_q, ok_q, done_q, ien_q, kick_q;
  logic [IW-1:0] idx_q;

  logic       tx_empty, tx_full, rx_empty, rx_full;
  logic [7:0] tx_head, rx_head, seq_rbyte;
  logic       cyc_done, cyc_fail;

  // named register events
  wire go_wr      = reg_wr && (reg_addr == OFS_GO) && reg_wdata[0];
  wire start_take = go_wr && !busy_q;
  wire len_valid  = burst_len_ok(len_q, BURST_MAX);
  wire [IW-1:0] idx_next = idx_q + 1'b1;
  wire last_cyc   = (8'(idx_next) == len_q);

  wire tx_push = reg_wr && (reg_addr == OFS_TXB) && !busy_q && !tx_full;
  wire tx_pop  = kick_q && dir_q;
  wire rx_push = cyc_done && !dir_q && !rx_full;
  wire rx_pop  = reg_rd && (reg_addr == OFS_RXB);

  lpcio_fifo #(.W(8), .DEPTH(BURST_MAX)) tx_q_i (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .din(reg_wdata[7:0]),
    .pop(tx_pop), .head(tx_head), .empty(tx_empty), .full(tx_full)
  );

  lpcio_fifo #(.W(8), .DEPTH(BURST_MAX)) rx_q_i (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .din(seq_rbyte),
    .pop(rx_pop), .head(rx_head), .empty(rx_empty), .full(rx_full)
  );

  lpcio_cycle #(.WAIT_MAX(WAIT_MAX)) cyc_i (
    .clk(clk), .rst_n(rst_n), .go(kick_q), .wr(dir_q),
    .port(cycle_port(port_q[15:0], 8'(idx_q), fixed_q)),
    .wbyte(tx_empty ? 8'h00 : tx_head),
    .lad_in(lad_in), .lframe_n(lframe_n), .lad_out(lad_out), .lad_oe(lad_oe),
    .cyc_done(cyc_done), .cyc_fail(cyc_fail), .rbyte(seq_rbyte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q   <= '0;
      dir_q   <= 1'b0;
      fixed_q <= 1'b0;
      port_q  <= '0;
      busy_q  <= 1'b0;
      ok_q    <= 1'b0;
      done_q  <= 1'b0;
      ien_q   <= 1'b0;
      kick_q  <= 1'b0;
      idx_q   <= '0;
    end else begin
      kick_q <= 1'b0;
      if (reg_wr && !busy_q) begin
        case (reg_addr)
          OFS_LEN:  len_q <= reg_wdata[7:0];
          OFS_CTL: begin
            dir_q   <= reg_wdata[0];
            fixed_q <= reg_wdata[3];
          end
          OFS_PORT: port_q <= reg_wdata;
          default: ;
        endcase
      end
      if (reg_wr && (reg_addr == OFS_INT)) begin
        ien_q <= reg_wdata[0];
        if (reg_wdata[1]) done_q <= 1'b0;
      end
      if (start_take) begin
        ok_q <= 1'b0;
        if (len_valid) begin
          busy_q <= 1'b1;
          idx_q  <= '0;
          kick_q <= 1'b1;
        end else begin
          done_q <= 1'b1;
        end
      end
      if (busy_q && cyc_fail) begin
        busy_q <= 1'b0;
        ok_q   <= 1'b0;
        done_q <= 1'b1;
      end else if (busy_q && cyc_done) begin
        if (last_cyc) begin
          busy_q <= 1'b0;
          ok_q   <= 1'b1;
          done_q <= 1'b1;
        end else begin
          idx_q  <= idx_next;
          kick_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_STAT: reg_rdata = {30'd0, ok_q, !busy_q};
      OFS_INT:  reg_rdata = {30'd0, done_q, ien_q};
      OFS_LEN:  reg_rdata = {24'd0, len_q};
      OFS_CTL:  reg_rdata = {28'd0, fixed_q, 2'b00, dir_q};
      OFS_PORT: reg_rdata = port_q;
      OFS_RXB:  reg_rdata = {24'd0, rx_empty ? 8'h00 : rx_head};
      default:  reg_rdata = '0;
    endcase
  end

  assign irq = ien_q && done_q;

  // R2
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |=> !lframe_n)
    else $error("burst start did not frame a cycle");

  // R11
  done_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q)
    else $error("burst ended without completion flag");

  // R13
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (8'(idx_q) < len_q))
    else $error("cycle index ran past burst length");

  // R8
  err_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cyc_fail) |=> (!busy_q && !ok_q && lframe_n))
    else $error("failed cycle did not abort the burst");

  // R10
  bad_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_take && !len_valid) |=> (!busy_q && done_q && lframe_n))
    else $error("invalid count launched a burst");

endmodule

// File: tb/lpc_io_host_tb_top.sv
module lpc_io_host_tb_top;

  localparam logic [7:0] A_GO = 8'h00, A_STAT = 8'h04, A_INT = 8'h08,
                         A_LEN = 8'h10, A_CTL = 8'h14, A_PORT = 8'h20,
                         A_TXB = 8'h24, A_RXB = 8'h28;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_rdata;
  logic        irq, lframe_n, lad_oe;
  logic [3:0]  lad_out;
  logic [3:0]  lad_in;

  int checks = 0;
  int fails = 0;
  longint tick = 0;

  // target model controls (written by tests only)
  int         tgt_nwait = 0;
  logic [3:0] tgt_wcode = 4'b0101;
  bit         tgt_bad = 0;
  logic [7:0] tgt_rbase = 8'h00;
  int         tgt_base = 0;

  // cycle log (written by the target model only)
  logic [3:0]  log_dir  [64];
  logic [15:0] log_addr [64];
  logic [7:0]  log_wd   [64];
  longint      log_t    [64];
  int          log_n = 0;

  always #4 clk = ~clk;

  lpc_io_host dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .irq(irq), .lframe_n(lframe_n), .lad_out(lad_out), .lad_oe(lad_oe),
    .lad_in(lad_in)
  );

  initial forever begin
    @(posedge clk);
    tick++;
  end

  // target: counts clocks k from the framing nibble and answers on lad_in
  initial begin
    int k, cur, ks, j;
    bit act, isw;
    logic [15:0] a;
    logic [7:0] rb;
    k = 0; cur = 0; act = 0; isw = 0; a = '0;
    lad_in = 4'hF;
    forever begin
      @(negedge clk);
      if (!lframe_n) begin
        k = 0; cur = log_n; act = 1; a = '0;
        if (log_n < 64) begin
          log_t[log_n] = tick;
          log_n++;
        end
      end else if (act) k++;
      lad_in = 4'hF;
      if (act && cur < 64) begin
        if (k == 1) begin
          isw = (lad_out == 4'b0010);
          log_dir[cur] = lad_out;
        end
        if (k >= 2 && k <= 5) begin
          a = {a[11:0], lad_out};
          log_addr[cur] = a;
        end
        if (isw && k == 6) log_wd[cur][3:0] = lad_out;
        if (isw && k == 7) log_wd[cur][7:4] = lad_out;
        ks = isw ? 10 : 8;
        rb = tgt_rbase + 8'(cur - tgt_base);
        if (k >= ks) begin
          j = k - ks;
          if (tgt_bad) lad_in = 4'b1010;
          else if (j < tgt_nwait) lad_in = tgt_wcode;
          else if (j == tgt_nwait) lad_in = 4'b0000;
          else if (!isw && j == tgt_nwait + 1) lad_in = rb[3:0];
          else if (!isw && j == tgt_nwait + 2) lad_in = rb[7:4];
        end
      end
    end
  end

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd_reg(A_STAT, s);
      if (s[0]) return;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd_reg(A_STAT, d); chk("R1", "status after reset", d, 32'h1);
    rd_reg(A_INT, d);  chk("R1", "int after reset", d, 32'h0);
    chk("R1", "irq after reset", irq, 0);
    chk("R1", "frame after reset", lframe_n, 1);
    chk("R1", "oe after reset", lad_oe, 0);
  endtask

  task automatic t_write_incr();
    logic [31:0] d;
    int b;
    wr_reg(A_LEN, 4); wr_reg(A_CTL, 32'h1); wr_reg(A_PORT, 32'h03F8);
    for (int i = 0; i < 4; i++) wr_reg(A_TXB, 32'(8'h11 * (i + 1)));
    b = log_n;
    wr_reg(A_GO, 1);
    rd_reg(A_STAT, d); chk("R2", "busy during burst", d[0], 0);
    wait_idle();
    chk("R2", "cycles in write burst", log_n - b, 4);
    for (int i = 0; i < 4; i++) begin
      chk("R3", "write dir nibble", log_dir[b+i], 4'b0010);
      chk("R5", "incrementing port", log_addr[b+i], 16'h03F8 + 16'(i));
      chk("R6", "write byte order", log_wd[b+i], 8'h11 * (i + 1));
    end
    for (int i = 0; i < 3; i++)
      chk("R3", "cycle spacing", log_t[b+i+1] - log_t[b+i], 14);
    rd_reg(A_STAT, d); chk("R2", "status after burst", d, 32'h3);
    rd_reg(A_INT, d);  chk("R11", "done set, enable clear", d, 32'h2);
    chk("R11", "irq masked", irq, 0);
  endtask

  task automatic t_read_fixed();
    logic [31:0] d;
    int b;
    wr_reg(A_INT, 32'h3);
    wr_reg(A_LEN, 3); wr_reg(A_CTL, 32'h8); wr_reg(A_PORT, 32'h0060);
    b = log_n; tgt_base = log_n; tgt_rbase = 8'h50;
    wr_reg(A_GO, 1);
    wait_idle();
    chk("R11", "irq after read burst", irq, 1);
    chk("R4", "cycles in read burst", log_n - b, 3);
    for (int i = 0; i < 3; i++) begin
      chk("R4", "read dir nibble", log_dir[b+i], 4'b0000);
      chk("R5", "fixed port", log_addr[b+i], 16'h0060);
    end
    for (int i = 0; i < 3; i++) begin
      rd_reg(A_RXB, d); chk("R4", "read byte order", d, 32'h50 + 32'(i));
    end
    rd_reg(A_RXB, d); chk("R4", "empty receive queue", d, 0);
    wr_reg(A_INT, 32'h3);
    chk("R11", "irq after clear", irq, 0);
    rd_reg(A_INT, d); chk("R11", "int after clear", d, 32'h1);
    wr_reg(A_INT, 32'h0);
  endtask

  task automatic t_bad_len();
    logic [31:0] d;
    int b;
    b = log_n;
    wr_reg(A_INT, 32'h2);
    wr_reg(A_LEN, 0); wr_reg(A_GO, 1);
    rd_reg(A_STAT, d); chk("R10", "status for count 0", d, 32'h1);
    rd_reg(A_INT, d);  chk("R10", "done for count 0", d, 32'h2);
    wr_reg(A_INT, 32'h2);
    wr_reg(A_LEN, 17); wr_reg(A_GO, 1);
    repeat (3) @(negedge clk);
    rd_reg(A_STAT, d); chk("R10", "status for count 17", d, 32'h1);
    rd_reg(A_INT, d);  chk("R10", "done for count 17", d, 32'h2);
    chk("R10", "no bus cycles", log_n - b, 0);
    wr_reg(A_INT, 32'h2);
  endtask

  task automatic t_waits();
    logic [31:0] d;
    int b;
    tgt_nwait = 256; tgt_wcode = 4'b0101;
    wr_reg(A_LEN, 1); wr_reg(A_CTL, 32'h1); wr_reg(A_PORT, 32'h0080);
    wr_reg(A_TXB, 32'hC3);
    b = log_n;
    wr_reg(A_GO, 1); wait_idle();
    rd_reg(A_STAT, d); chk("R7", "256 short waits ok", d, 32'h3);
    chk("R7", "byte after waits", log_wd[b], 8'hC3);
    tgt_wcode = 4'b0110; tgt_base = log_n; tgt_rbase = 8'h9E;
    wr_reg(A_CTL, 32'h0);
    wr_reg(A_GO, 1); wait_idle();
    rd_reg(A_STAT, d); chk("R7", "256 long waits ok", d, 32'h3);
    rd_reg(A_RXB, d);  chk("R7", "read byte after waits", d, 32'h9E);
    tgt_nwait = 0;
  endtask

  task automatic t_sync_err();
    logic [31:0] d;
    int b;
    tgt_bad = 1;
    wr_reg(A_LEN, 3); wr_reg(A_CTL, 32'h0); wr_reg(A_PORT, 32'h0100);
    b = log_n;
    wr_reg(A_GO, 1); wait_idle();
    repeat (20) @(negedge clk);
    chk("R8", "burst aborted after first cycle", log_n - b, 1);
    rd_reg(A_STAT, d); chk("R8", "status after error", d, 32'h1);
    rd_reg(A_INT, d);  chk("R8", "done after error", d, 32'h2);
    rd_reg(A_RXB, d);  chk("R8", "no byte received", d, 0);
    tgt_bad = 0;
    wr_reg(A_INT, 32'h2);
  endtask

  task automatic t_timeout();
    logic [31:0] d;
    int b;
    tgt_nwait = 257; tgt_wcode = 4'b0101;
    wr_reg(A_LEN, 2); wr_reg(A_CTL, 32'h0); wr_reg(A_PORT, 32'h0110);
    b = log_n;
    wr_reg(A_GO, 1); wait_idle();
    repeat (20) @(negedge clk);
    chk("R9", "timeout aborts burst", log_n - b, 1);
    rd_reg(A_STAT, d); chk("R9", "status after timeout", d, 32'h1);
    rd_reg(A_RXB, d);  chk("R9", "no byte after timeout", d, 0);
    tgt_nwait = 0;
  endtask

  task automatic t_busy_ignore();
    logic [31:0] d;
    int b;
    wr_reg(A_LEN, 2); wr_reg(A_CTL, 32'h0); wr_reg(A_PORT, 32'h0200);
    b = log_n; tgt_base = log_n; tgt_rbase = 8'h70;
    wr_reg(A_GO, 1);
    wr_reg(A_LEN, 5); wr_reg(A_CTL, 32'h9); wr_reg(A_PORT, 32'h0999);
    wr_reg(A_TXB, 32'hEE); wr_reg(A_GO, 1);
    wait_idle();
    repeat (20) @(negedge clk);
    chk("R12", "extra start ignored", log_n - b, 2);
    rd_reg(A_LEN, d);  chk("R12", "count kept", d, 2);
    rd_reg(A_CTL, d);  chk("R12", "command kept", d, 0);
    rd_reg(A_PORT, d); chk("R12", "port kept", d, 32'h0200);
    rd_reg(A_RXB, d);  chk("R12", "first read byte", d, 32'h70);
    rd_reg(A_RXB, d);  chk("R12", "second read byte", d, 32'h71);
    chk("R12", "second port", log_addr[b+1], 16'h0201);
    wr_reg(A_LEN, 1); wr_reg(A_CTL, 32'h1); wr_reg(A_PORT, 32'h0300);
    wr_reg(A_TXB, 32'h5A);
    b = log_n;
    wr_reg(A_GO, 1); wait_idle();
    chk("R12", "busy push was dropped", log_wd[b], 8'h5A);
  endtask

  task automatic t_max_burst();
    logic [31:0] d;
    int b;
    wr_reg(A_LEN, 16); wr_reg(A_CTL, 32'h9); wr_reg(A_PORT, 32'h02F8);
    for (int i = 0; i < 16; i++) wr_reg(A_TXB, 32'(8'(i * 7 + 3)));
    b = log_n;
    wr_reg(A_GO, 1); wait_idle();
    chk("R13", "sixteen cycles", log_n - b, 16);
    for (int i = 0; i < 16; i++) begin
      chk("R13", "fixed port in long burst", log_addr[b+i], 16'h02F8);
      chk("R6", "byte order in long burst", log_wd[b+i], 8'(i * 7 + 3));
    end
    rd_reg(A_STAT, d); chk("R13", "long burst ok", d, 32'h3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_incr();
    t_read_fixed();
    t_bad_len();
    t_waits();
    t_sync_err();
    t_timeout();
    t_busy_ignore();
    t_max_burst();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule